// File: doc/BRIEF.md
# Periodic Parallel-Converter Sampling Sequencer

This block sits on the host side of a 16-bit successive-approximation converter that has a parallel data bus. The converter is controlled by four lines: an active-low select, a read/convert level, a lane-swap select and a BUSY status line. While its run input is high, the sequencer starts a conversion once every programmable sample interval. For each conversion it sets up read/convert, asserts the convert pulse, releases both control lines, and waits for BUSY to rise. It then enables the bus and captures the result. The result is read either as one 16-bit word or as two byte reads on the low lane.

Each captured sample appears on a 16-bit output register together with a single-cycle valid strobe. BUSY is treated as asynchronous and passes through a two-flop synchronizer. A watchdog bounds how long the sequencer waits for BUSY to rise. If BUSY stays low for too long, the sequencer emits a one-cycle timeout pulse and returns to idle without producing a sample.

All timing is expressed in clock cycles through parameters. At 100 MHz the defaults are:
- a 1-cycle setup of read/convert before the select edge;
- a 5-cycle (50 ns) convert pulse, which must stay between 4 and 500 cycles;
- a 9-cycle bus access wait;
- a 1000-cycle (10 us) sample interval;
- a 1600-cycle BUSY watchdog.

Top module: `adc_sample_seq`

## Requirements
- R1: During and right after reset, adc_cs_n_o and adc_rc_o are high, and adc_lane_o, smp_valid_o and timeout_o are low.
- R2: When run_i is low, no falling edge appears on adc_rc_o. When run_i rises from a long idle, adc_rc_o falls on the first clock edge that samples run_i high.
- R3: While run_i stays high and each sequence fits in the interval, consecutive falling edges of adc_rc_o are exactly SAMPLE_CYC cycles apart.
- R4: adc_rc_o falls exactly SETUP_CYC cycles before adc_cs_n_o falls to start a conversion.
- R5: adc_cs_n_o and adc_rc_o are both low for exactly CONV_LOW_CYC cycles. They then return high on the same edge, which is before the converter can raise BUSY.
- R6: The bus is enabled (adc_cs_n_o low with adc_rc_o high) only after a rising edge of BUSY is seen while waiting. That happens 3 edges after BUSY rises, counting two synchronizer flops and the state register. A BUSY rise at any other time is ignored.
- R7: In word mode (byte_mode_i = 0), adc_lane_o stays low. adc_data_i[15:0] is captured ACCESS_CYC cycles after the bus is enabled.
- R8: Each sample is presented on smp_data_o with smp_valid_o high for exactly one cycle, starting on the capture edge.
- R9: In byte mode (byte_mode_i = 1), the first read has adc_lane_o low and places adc_data_i[7:0] in result bits 7:0. The second read has adc_lane_o high and places adc_data_i[7:0] in result bits 15:8. adc_data_i[15:8] is ignored. The valid strobe comes 2*ACCESS_CYC cycles after the bus is enabled.
- R10: If BUSY has not risen BUSY_TMO_CYC cycles after the control lines are released, timeout_o pulses for one cycle on that edge. No sample is produced, both control lines stay high, and the next interval proceeds normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Enables periodic sampling |
| byte_mode_i | input | 1 | 1 = two byte reads on the low lane, 0 = one word read |
| adc_busy_i | input | 1 | Converter BUSY, low while converting (asynchronous) |
| adc_data_i | input | DW | Converter parallel data bus |
| adc_cs_n_o | output | 1 | Converter select, active low |
| adc_rc_o | output | 1 | Read (high) / convert (low) level |
| adc_lane_o | output | 1 | Lane swap select for byte reads |
| smp_valid_o | output | 1 | One-cycle strobe for a new sample |
| smp_data_o | output | DW | Assembled sample |
| timeout_o | output | 1 | One-cycle pulse when the BUSY watchdog expires |

## Verification
Every result has a fixed due cycle, counted from the edge that caused it:
- the convert setup is due SETUP_CYC edges after read/convert falls;
- the pulse end is due CONV_LOW_CYC edges after the select falls;
- the bus enable is due 3 edges after BUSY rises;
- the valid strobe is due ACCESS_CYC (word mode) or 2*ACCESS_CYC (byte mode) edges after the enable;
- the timeout is due BUSY_TMO_CYC edges after the release.

A falling-edge monitor records the edge index of each transition. Each check compares the difference between two recorded indices with its expected value, so a result that is one cycle early or one cycle late is reported. The bench drives inputs, and reads the recorded values, 1 ns after a falling edge.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_PULSE = 3'd2,
    ST_WAIT  = 3'd3,
    ST_RD_LO = 3'd4,
    ST_RD_HI = 3'd5
  } seq_st_t;
endpackage

// File: rtl/seq_downcnt.sv
`timescale 1ns/1ps
module seq_downcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load | (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/seq_sync_rise.sv
`timescale 1ns/1ps
module seq_sync_rise #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  logic s1_q, s2_q, dly_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= RST_VAL;
      s2_q  <= RST_VAL;
      dly_q <= RST_VAL;
    end else begin
      s1_q  <= async_i;
      s2_q  <= s1_q;
      dly_q <= s2_q;
    end
  end

  assign level_o = s2_q;
  assign rise_o  = s2_q & ~dly_q;
endmodule

// File: rtl/adc_sample_seq.sv
`timescale 1ns/1ps
module adc_sample_seq
  import adc_seq_pkg::*;
#(
  parameter int DW           = 16,
  parameter int SETUP_CYC    = 1,
  parameter int CONV_LOW_CYC = 5,
  parameter int ACCESS_CYC   = 9,
  parameter int SAMPLE_CYC   = 1000,
  parameter int BUSY_TMO_CYC = 1600
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          byte_mode_i,
  input  logic          adc_busy_i,
  input  logic [DW-1:0] adc_data_i,
  output logic          adc_cs_n_o,
  output logic          adc_rc_o,
  output logic          adc_lane_o,
  output logic          smp_valid_o,
  output logic [DW-1:0] smp_data_o,
  output logic          timeout_o
);
  localparam int HW     = DW / 2;
  localparam int PH_M1  = (SETUP_CYC > CONV_LOW_CYC) ? SETUP_CYC : CONV_LOW_CYC;
  localparam int PH_M2  = (ACCESS_CYC > BUSY_TMO_CYC) ? ACCESS_CYC : BUSY_TMO_CYC;
  localparam int PH_MAX = (PH_M1 > PH_M2) ? PH_M1 : PH_M2;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int SMP_W  = $clog2(SAMPLE_CYC + 1);
  localparam logic [PH_W-1:0]  LD_SETUP  = PH_W'(SETUP_CYC - 1);
  localparam logic [PH_W-1:0]  LD_PULSE  = PH_W'(CONV_LOW_CYC - 1);
  localparam logic [PH_W-1:0]  LD_WAIT   = PH_W'(BUSY_TMO_CYC - 1);
  localparam logic [PH_W-1:0]  LD_ACCESS = PH_W'(ACCESS_CYC - 1);
  localparam logic [SMP_W-1:0] LD_SMP    = SMP_W'(SAMPLE_CYC - 1);

  seq_st_t st_q, st_d;
  logic busy_lvl, busy_rise;
  logic ph_load, ph_zero, smp_load, smp_zero, start;
  logic [PH_W-1:0]  ph_val;
  logic [SMP_W-1:0] smp_val;
  logic word_we, lo_we, hi_we, valid_d, tmo_d;
  logic cs_n_d, rc_d, lane_d;

  seq_sync_rise #(.RST_VAL(1'b1)) u_busy_sync (
    .clk(clk), .rst_n(rst_n), .async_i(adc_busy_i),
    .level_o(busy_lvl), .rise_o(busy_rise)
  );

  seq_downcnt #(.W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
  );

  seq_downcnt #(.W(SMP_W)) u_interval (
    .clk(clk), .rst_n(rst_n), .load(smp_load), .load_val(smp_val), .zero(smp_zero)
  );

  assign start    = (st_q == ST_IDLE) & run_i & smp_zero;
  assign smp_load = start | ~run_i;
  assign smp_val  = start ? LD_SMP : '0;

  // next-state and strobe decode
  always_comb begin
    st_d    = st_q;
    word_we = 1'b0;
    lo_we   = 1'b0;
    hi_we   = 1'b0;
    valid_d = 1'b0;
    tmo_d   = 1'b0;
    unique case (st_q)
      ST_IDLE:  if (start) st_d = ST_SETUP;
      ST_SETUP: if (ph_zero) st_d = ST_PULSE;
      ST_PULSE: if (ph_zero) st_d = ST_WAIT;
      ST_WAIT: begin
        if (busy_rise) st_d = ST_RD_LO;
        else if (ph_zero) begin
          st_d  = ST_IDLE;
          tmo_d = 1'b1;
        end
      end
      ST_RD_LO: if (ph_zero) begin
        if (byte_mode_i) begin
          st_d  = ST_RD_HI;
          lo_we = 1'b1;
        end else begin
          st_d    = ST_IDLE;
          word_we = 1'b1;
          valid_d = 1'b1;
        end
      end
      ST_RD_HI: if (ph_zero) begin
        st_d    = ST_IDLE;
        hi_we   = 1'b1;
        valid_d = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // dwell load on every state change, registered pin levels from next state
  always_comb begin
    ph_load = (st_d != st_q);
    unique case (st_d)
      ST_SETUP:           ph_val = LD_SETUP;
      ST_PULSE:           ph_val = LD_PULSE;
      ST_WAIT:            ph_val = LD_WAIT;
      ST_RD_LO, ST_RD_HI: ph_val = LD_ACCESS;
      default:            ph_val = '0;
    endcase
    cs_n_d = !((st_d == ST_PULSE) || (st_d == ST_RD_LO) || (st_d == ST_RD_HI));
    rc_d   = !((st_d == ST_SETUP) || (st_d == ST_PULSE));
    lane_d = (st_d == ST_RD_HI);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      adc_cs_n_o  <= 1'b1;
      adc_rc_o    <= 1'b1;
      adc_lane_o  <= 1'b0;
      smp_valid_o <= 1'b0;
      timeout_o   <= 1'b0;
    end else begin
      st_q        <= st_d;
      adc_cs_n_o  <= cs_n_d;
      adc_rc_o    <= rc_d;
      adc_lane_o  <= lane_d;
      smp_valid_o <= valid_d;
      timeout_o   <= tmo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_data_o <= '0;
    end else begin
      if (word_we) smp_data_o          <= adc_data_i;
      if (lo_we)   smp_data_o[HW-1:0]  <= adc_data_i[HW-1:0];
      if (hi_we)   smp_data_o[DW-1:HW] <= adc_data_i[HW-1:0];
    end
  end

  // R4
  rc_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(adc_cs_n_o) && !adc_rc_o) |-> $past(!adc_rc_o));
  // R5
  rel_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(adc_cs_n_o) && $past(!adc_rc_o)) |-> adc_rc_o);
  // R6
  busy_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_rise |-> (adc_cs_n_o && adc_rc_o));
  // R6
  no_rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adc_cs_n_o && adc_rc_o) |-> busy_lvl);
  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_o |=> !smp_valid_o);
  // R10
  tmo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> (adc_cs_n_o && adc_rc_o && !smp_valid_o));
endmodule

// File: tb/adc_sample_seq_bench.sv
`timescale 1ns/1ps
module adc_sample_seq_bench;
  localparam int DW = 16, SETUP = 2, CLOW = 5, ACC = 4, SMP = 120, TMO = 80, CONV = 50;

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, bmode = 1'b0;
  logic busy, stuck = 1'b0;
  logic [DW-1:0] val = '0, bus;
  logic cs_n, rc, lane, valid, tmo;
  logic [DW-1:0] data;
  int cyc = 0, n_chk = 0, n_bad = 0;
  int cv_cnt, busy_rise_cyc;
  int rc_fall = 0, rc_fall_prev = 0, cv_fall = 0, rd_fall = 0, pulse_end = 0;
  int valid_cyc = 0, tmo_cyc = 0, n_rcfall = 0, n_valid = 0, n_tmo = 0;
  int n_rd_busy = 0, n_bad_rel = 0, n_lane_word = 0;
  logic cs_q = 1'b1, rc_q = 1'b1;
  logic [DW-1:0] vdata = '0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_sample_seq #(.DW(DW), .SETUP_CYC(SETUP), .CONV_LOW_CYC(CLOW), .ACCESS_CYC(ACC),
                   .SAMPLE_CYC(SMP), .BUSY_TMO_CYC(TMO)) u_adc_sample_seq (
    .clk(clk), .rst_n(rst_n), .run_i(run), .byte_mode_i(bmode), .adc_busy_i(busy),
    .adc_data_i(bus), .adc_cs_n_o(cs_n), .adc_rc_o(rc), .adc_lane_o(lane),
    .smp_valid_o(valid), .smp_data_o(data), .timeout_o(tmo));

  // converter model
  assign bus = (!cs_n && rc) ? (lane ? {val[7:0], val[15:8]} : val) : '0;
  always @(negedge clk) begin
    if (!rst_n) begin
      busy <= 1'b1; cv_cnt <= 0; busy_rise_cyc <= 0;
    end else if (busy && !cs_n && !rc) begin
      busy <= 1'b0; cv_cnt <= CONV;
    end else if (!busy && !stuck) begin
      if (cv_cnt <= 1) begin busy <= 1'b1; busy_rise_cyc <= cyc; end
      else cv_cnt <= cv_cnt - 1;
    end
  end

  // edge monitor
  always @(negedge clk) if (rst_n) begin
    if (rc_q && !rc) begin rc_fall_prev = rc_fall; rc_fall = cyc; n_rcfall++; end
    if (cs_q && !cs_n) begin if (!rc) cv_fall = cyc; else rd_fall = cyc; end
    if (!cs_q && cs_n && !rc_q) begin pulse_end = cyc; if (!rc) n_bad_rel++; end
    if (!cs_n && rc && !busy) n_rd_busy++;
    if (!bmode && lane) n_lane_word++;
    if (valid) begin n_valid++; valid_cyc = cyc; vdata = data; end
    if (tmo) begin n_tmo++; tmo_cyc = cyc; end
    cs_q = cs_n; rc_q = rc;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wait_valid();
    int n0 = n_valid;
    for (int i = 0; i < 2000 && n_valid == n0; i++) step(1);
  endtask

  task automatic t_reset();
    step(1);
    chk(cs_n && rc && !lane && !valid && !tmo, "R1 in reset", {cs_n, rc, lane, valid, tmo}, 5'b11000);
    rst_n = 1'b1;
    step(3);
    chk(cs_n && rc && !lane && !valid && !tmo, "R1 after reset", {cs_n, rc, lane, valid, tmo}, 5'b11000);
    chk(n_rcfall == 0, "R2 idle while run low", n_rcfall, 0);
  endtask

  task automatic t_word();
    int m;
    val = 16'hA5C3; bmode = 1'b0;
    m = cyc; run = 1'b1;
    wait_valid();
    chk(rc_fall == m + 1, "R2 first start", rc_fall, m + 1);
    chk(cv_fall - rc_fall == SETUP, "R4 setup", cv_fall - rc_fall, SETUP);
    chk(pulse_end - cv_fall == CLOW, "R5 pulse width", pulse_end - cv_fall, CLOW);
    chk(rd_fall - busy_rise_cyc == 3, "R6 enable after busy", rd_fall - busy_rise_cyc, 3);
    chk(valid_cyc - rd_fall == ACC, "R7 access wait", valid_cyc - rd_fall, ACC);
    chk(vdata == 16'hA5C3, "R8 word data", vdata, 16'hA5C3);
    step(1);
    chk(!valid, "R8 one-cycle strobe", valid, 0);
    val = 16'h0000;
    wait_valid();
    chk(rc_fall - rc_fall_prev == SMP, "R3 interval", rc_fall - rc_fall_prev, SMP);
    chk(vdata == 16'h0000, "R8 zero code", vdata, 0);
    val = 16'hFFFF;
    wait_valid();
    chk(vdata == 16'hFFFF, "R8 full code", vdata, 16'hFFFF);
    chk(rc_fall - rc_fall_prev == SMP, "R3 interval again", rc_fall - rc_fall_prev, SMP);
    chk(n_lane_word == 0, "R7 lane low in word mode", n_lane_word, 0);
  endtask

  task automatic t_byte();
    bmode = 1'b1; val = 16'h8001;
    wait_valid();
    chk(vdata == 16'h8001, "R9 byte data", vdata, 16'h8001);
    chk(valid_cyc - rd_fall == 2 * ACC, "R9 two reads", valid_cyc - rd_fall, 2 * ACC);
    val = 16'h7FFE;
    wait_valid();
    chk(vdata == 16'h7FFE, "R9 byte data 2", vdata, 16'h7FFE);
  endtask

  task automatic t_stop();
    int r0, v0;
    run = 1'b0; bmode = 1'b0;
    r0 = n_rcfall; v0 = n_valid;
    step(3 * SMP);
    chk(n_rcfall == r0, "R2 no convert when stopped", n_rcfall - r0, 0);
    chk(n_valid == v0, "R2 no sample when stopped", n_valid - v0, 0);
  endtask

  task automatic t_timeout();
    int v0, t0;
    v0 = n_valid; t0 = n_tmo;
    stuck = 1'b1; run = 1'b1;
    for (int i = 0; i < 1000 && n_tmo == t0; i++) step(1);
    run = 1'b0;
    chk(n_tmo == t0 + 1, "R10 timeout raised", n_tmo - t0, 1);
    chk(tmo_cyc - pulse_end == TMO, "R10 timeout delay", tmo_cyc - pulse_end, TMO);
    chk(n_valid == v0, "R10 no sample", n_valid - v0, 0);
    step(1);
    chk(!tmo && cs_n && rc, "R10 idle after timeout", {tmo, cs_n, rc}, 3'b011);
    stuck = 1'b0;
    step(CONV + 20);
    chk(n_valid == v0 && cs_n, "R6 late busy ignored", n_valid - v0, 0);
    val = 16'h1234; run = 1'b1;
    wait_valid();
    chk(vdata == 16'h1234, "R10 recovery sample", vdata, 16'h1234);
    run = 1'b0;
  endtask

  initial begin
    t_reset();
    t_word();
    t_byte();
    t_stop();
    t_timeout();
    chk(n_rd_busy == 0, "R6 no read during conversion", n_rd_busy, 0);
    chk(n_bad_rel == 0, "R5 joint release", n_bad_rel, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule